// File: doc/BRIEF.md
# Special-Purpose Register Read Unit

This unit executes the read direction of a special-purpose register move. It accepts a 32-bit instruction word with a valid strobe and checks that the word carries the expected primary and extended opcodes with a clear reserved bit. It then extracts the destination general-purpose register index and rebuilds the logical register number from an encoding in which the two 5-bit halves are transposed. From that number it selects a value for writeback.

The selected value comes from one of four kinds of source. Live registers are supplied on input ports (fixed-point exception, link, count and vector-save mask). A 64-bit time base is kept inside the block and read as a low or a high half. A fixed processor version constant has its own number. A set of known but unmodelled registers reads as zero. Any other number also reads as zero and raises a warning pulse.

All strobes and the result are registered, so they appear one cycle after the valid strobe. The pipeline writes the result back to the general-purpose register file and advances the PC by 4 when the next-PC flag is high.

Top module: `spr_read_unit`

## Requirements
- R1: A valid word is accepted when bits [31:26] equal 31, bits [10:1] equal 339 and bit [0] is zero. In the next cycle `wr_en` and `pc_adv` are both high for exactly one cycle and `illegal` is low.
- R2: `dest_idx` presents bits [25:21] of the accepted word from the cycle after the valid strobe.
- R3: The logical register number is {word[15:11], word[20:16]}. For example, word[20:11] = 0x100 selects register 8.
- R4: Numbers 1, 8, 9 and 256 return `xer_val`, `link_val`, `count_val` and `vsave_val`, as sampled in the cycle of the valid strobe.
- R5: The time base is a 64-bit counter that resets to TB_INIT (default 0x00000000_FFFFFFFC) and increments by one on each clock edge where `tick_en` is high. Number 268 returns bits [31:0] and number 269 returns bits [63:32] of the value held in the cycle of the valid strobe, before that edge's increment.
- R6: Number 287 returns PVR_VALUE (default 0x00710800).
- R7: Numbers 18, 19, 272, 273, 274, 275, 1008, 1009 and 1023 return zero, with `wr_en` high and `warn_unmod` low.
- R8: Any number not listed in R4 to R7 returns zero, with `wr_en` high and `warn_unmod` high for one cycle.
- R9: A valid word with a wrong primary or extended opcode, or with bit [0] set, gives `illegal` high for one cycle. In that cycle `wr_en`, `pc_adv` and `warn_unmod` stay low and the result is zero.
- R10: In the cycle after a cycle with `instr_valid` low, all four strobes are low and `result` and `dest_idx` keep their previous values.
- R11: After reset, `result` and `dest_idx` are zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-base increment enable |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word, bit 31 is the first big-endian bit |
| xer_val | input | 32 | Packed fixed-point exception register |
| link_val | input | 32 | Link register |
| count_val | input | 32 | Count register |
| vsave_val | input | 32 | Vector-save mask register |
| dest_idx | output | 5 | Destination register index |
| result | output | 32 | Value to write back |
| wr_en | output | 1 | Writeback enable |
| pc_adv | output | 1 | Advance the PC by 4 |
| warn_unmod | output | 1 | An unmodelled register number was read |
| illegal | output | 1 | The word was not a valid register read |

## Verification
Directed words cover each live, constant and stubbed number, and include one raw word with field 0x100 to show that the halves are un-swapped rather than taken as written. The time base is read just below and just above the 32-bit carry, which shows whether the two halves are taken from the same counter value. Random words mix correct, corrupted-opcode and reserved-bit-set encodings with random register numbers and random tick enables. These patterns separate a result that is wrongly zero from a wrong warning, and a legal word from an illegal one. Idle cycles placed between words show whether any strobe leaks out and whether the held outputs stay stable.

// File: rtl/spr_rd_pkg.sv
package spr_rd_pkg;

   localparam int unsigned OPC_PRIMARY = 31;
   localparam int unsigned OPC_EXT     = 339;

   localparam int unsigned NUM_XER   = 1;
   localparam int unsigned NUM_LR    = 8;
   localparam int unsigned NUM_CTR   = 9;
   localparam int unsigned NUM_VSAVE = 256;
   localparam int unsigned NUM_TBL   = 268;
   localparam int unsigned NUM_TBU   = 269;
   localparam int unsigned NUM_PVR   = 287;

   localparam int unsigned N_STUB = 9;

   typedef enum logic [2:0] {
      SRC_ZERO, SRC_XER, SRC_LR, SRC_CTR, SRC_VSAVE, SRC_TBL, SRC_TBU, SRC_PVR
   } spr_src_e;

   typedef struct packed {
      logic       legal;
      logic [4:0] rt;
      logic [9:0] num;
   } mfspr_dec_t;

   function automatic logic [9:0] stub_num(input int unsigned i);
      case (i)
         0:       return 10'd18;
         1:       return 10'd19;
         2:       return 10'd272;
         3:       return 10'd273;
         4:       return 10'd274;
         5:       return 10'd275;
         6:       return 10'd1008;
         7:       return 10'd1009;
         default: return 10'd1023;
      endcase
   endfunction

endpackage

// File: rtl/spr_field_decode.sv
module spr_field_decode
   import spr_rd_pkg::*;
#(
   parameter int unsigned INSN_W = 32
) (
   input  logic [INSN_W-1:0] insn,
   output mfspr_dec_t        dec
);
   localparam int unsigned HALF_W = 5;

   generate
      if (INSN_W != 32) begin : g_bad_width
         $error("spr_field_decode: INSN_W must be 32");
      end
   endgenerate

   logic [5:0] opc_pri;
   logic [9:0] opc_ext;
   logic       rsvd;

   always_comb begin
      opc_pri   = insn[31:26];
      opc_ext   = insn[10:1];
      rsvd      = insn[0];
      dec.rt    = insn[25:21];
      dec.num   = {insn[11 +: HALF_W], insn[16 +: HALF_W]};
      dec.legal = (opc_pri == 6'(OPC_PRIMARY)) && (opc_ext == 10'(OPC_EXT)) && !rsvd;
   end

endmodule

// File: rtl/spr_timebase.sv
module spr_timebase #(
   parameter int unsigned     TB_W    = 64,
   parameter logic [TB_W-1:0] TB_INIT = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   output logic [TB_W-1:0] count
);
   generate
      if (TB_W < 2) begin : g_bad_width
         $error("spr_timebase: TB_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= TB_INIT;
      else if (tick_en) count <= count + TB_W'(1);
   end

endmodule

// File: rtl/spr_read_mux.sv
module spr_read_mux
   import spr_rd_pkg::*;
#(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     TB_W      = 64,
   parameter logic [XLEN-1:0] PVR_VALUE = 32'h0071_0800
) (
   input  logic [9:0]      num,
   input  logic [XLEN-1:0] xer_val,
   input  logic [XLEN-1:0] link_val,
   input  logic [XLEN-1:0] count_val,
   input  logic [XLEN-1:0] vsave_val,
   input  logic [TB_W-1:0] tb_now,
   output logic [XLEN-1:0] value,
   output logic            unmod
);
   generate
      if (TB_W != 2 * XLEN) begin : g_bad_tb
         $error("spr_read_mux: TB_W must be twice XLEN");
      end
   endgenerate

   logic [N_STUB-1:0] stub_hit;
   spr_src_e          src;

   for (genvar g = 0; g < N_STUB; g++) begin : g_stub
      assign stub_hit[g] = (num == stub_num(g));
   end

   always_comb begin
      case (num)
         10'(NUM_XER):   src = SRC_XER;
         10'(NUM_LR):    src = SRC_LR;
         10'(NUM_CTR):   src = SRC_CTR;
         10'(NUM_VSAVE): src = SRC_VSAVE;
         10'(NUM_TBL):   src = SRC_TBL;
         10'(NUM_TBU):   src = SRC_TBU;
         10'(NUM_PVR):   src = SRC_PVR;
         default:        src = SRC_ZERO;
      endcase
      unmod = (src == SRC_ZERO) && (stub_hit == '0);
   end

   always_comb begin
      case (src)
         SRC_XER:   value = xer_val;
         SRC_LR:    value = link_val;
         SRC_CTR:   value = count_val;
         SRC_VSAVE: value = vsave_val;
         SRC_TBL:   value = tb_now[XLEN-1:0];
         SRC_TBU:   value = tb_now[TB_W-1:XLEN];
         SRC_PVR:   value = PVR_VALUE;
         default:   value = '0;
      endcase
   end

endmodule

// File: rtl/spr_read_unit.sv
module spr_read_unit
   import spr_rd_pkg::*;
#(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     TB_W      = 2 * XLEN,
   parameter logic [XLEN-1:0] PVR_VALUE = 32'h0071_0800,
   parameter logic [TB_W-1:0] TB_INIT   = 64'h0000_0000_FFFF_FFFC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   input  logic            instr_valid,
   input  logic [31:0]     instr_word,
   input  logic [XLEN-1:0] xer_val,
   input  logic [XLEN-1:0] link_val,
   input  logic [XLEN-1:0] count_val,
   input  logic [XLEN-1:0] vsave_val,
   output logic [4:0]      dest_idx,
   output logic [XLEN-1:0] result,
   output logic            wr_en,
   output logic            pc_adv,
   output logic            warn_unmod,
   output logic            illegal
);
   mfspr_dec_t      dec;
   logic [TB_W-1:0] tb_now;
   logic [XLEN-1:0] sel_value;
   logic            sel_unmod;

   spr_field_decode #(.INSN_W(32)) u_dec (
      .insn (instr_word),
      .dec  (dec)
   );

   spr_timebase #(.TB_W(TB_W), .TB_INIT(TB_INIT)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .count   (tb_now)
   );

   spr_read_mux #(.XLEN(XLEN), .TB_W(TB_W), .PVR_VALUE(PVR_VALUE)) u_mux (
      .num       (dec.num),
      .xer_val   (xer_val),
      .link_val  (link_val),
      .count_val (count_val),
      .vsave_val (vsave_val),
      .tb_now    (tb_now),
      .value     (sel_value),
      .unmod     (sel_unmod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_idx   <= '0;
         result     <= '0;
         wr_en      <= 1'b0;
         pc_adv     <= 1'b0;
         warn_unmod <= 1'b0;
         illegal    <= 1'b0;
      end else begin
         wr_en      <= instr_valid && dec.legal;
         pc_adv     <= instr_valid && dec.legal;
         warn_unmod <= instr_valid && dec.legal && sel_unmod;
         illegal    <= instr_valid && !dec.legal;
         if (instr_valid) begin
            dest_idx <= dec.rt;
            result   <= dec.legal ? sel_value : '0;
         end
      end
   end

endmodule

// File: rtl/spr_read_checker.sv
module spr_read_checker #(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     TB_W      = 64,
   parameter logic [XLEN-1:0] PVR_VALUE = 32'h0071_0800
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick_en,
   input logic            instr_valid,
   input logic            dec_legal,
   input logic [9:0]      dec_num,
   input logic [TB_W-1:0] tb_now,
   input logic [4:0]      dest_idx,
   input logic [XLEN-1:0] result,
   input logic            wr_en,
   input logic            pc_adv,
   input logic            warn_unmod,
   input logic            illegal
);
   assert_wr_pc_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en == pc_adv);

   assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!wr_en && !pc_adv && !warn_unmod && result == '0));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> (!wr_en && !illegal && !warn_unmod && !pc_adv));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> ($stable(result) && $stable(dest_idx)));

   assert_warn_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      warn_unmod |-> (wr_en && result == '0));

   assert_tb_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> tb_now == $past(tb_now) + TB_W'(1));

   assert_pvr_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && dec_legal && dec_num == 10'd287) |=> result == PVR_VALUE);

endmodule

bind spr_read_unit spr_read_checker #(
   .XLEN(XLEN), .TB_W(TB_W), .PVR_VALUE(PVR_VALUE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .instr_valid (instr_valid),
   .dec_legal   (dec.legal),
   .dec_num     (dec.num),
   .tb_now      (tb_now),
   .dest_idx    (dest_idx),
   .result      (result),
   .wr_en       (wr_en),
   .pc_adv      (pc_adv),
   .warn_unmod  (warn_unmod),
   .illegal     (illegal)
);

// File: tb/spr_read_unit_bench.sv
`timescale 1ns/1ps
module spr_read_unit_bench;
   localparam logic [63:0] TB_START = 64'h0000_0000_FFFF_FFFC;
   localparam logic [31:0] PVR      = 32'h0071_0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [31:0] xer_val = '0, link_val = '0, count_val = '0, vsave_val = '0;
   logic [4:0]  dest_idx;
   logic [31:0] result;
   logic        wr_en, pc_adv, warn_unmod, illegal;

   int errors = 0;
   int checks = 0;
   logic [63:0] tb_model = TB_START;
   logic [31:0] last_result = '0;
   logic [4:0]  last_dest = '0;

   always #2 clk = ~clk;

   spr_read_unit u_spr_read_unit (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .instr_valid(instr_valid),
      .instr_word(instr_word), .xer_val(xer_val), .link_val(link_val),
      .count_val(count_val), .vsave_val(vsave_val), .dest_idx(dest_idx),
      .result(result), .wr_en(wr_en), .pc_adv(pc_adv),
      .warn_unmod(warn_unmod), .illegal(illegal)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_word(input logic [4:0] rt, input logic [9:0] n);
      return {6'd31, rt, n[4:0], n[9:5], 10'd339, 1'b0};
   endfunction

   // Expected {warn, value} for a logical register number, per R4..R8
   function automatic logic [32:0] expect_of(input logic [9:0] n, input logic [63:0] tbv);
      case (n)
         10'd1:   return {1'b0, xer_val};
         10'd8:   return {1'b0, link_val};
         10'd9:   return {1'b0, count_val};
         10'd256: return {1'b0, vsave_val};
         10'd268: return {1'b0, tbv[31:0]};
         10'd269: return {1'b0, tbv[63:32]};
         10'd287: return {1'b0, PVR};
         10'd18, 10'd19, 10'd272, 10'd273, 10'd274, 10'd275,
         10'd1008, 10'd1009, 10'd1023: return {1'b0, 32'd0};
         default: return {1'b1, 32'd0};
      endcase
   endfunction

   // Drive one cycle at a negedge, check one cycle later away from the edge.
   task automatic step(input string tag, input logic vld, input logic [31:0] w, input logic tk);
      logic        legal;
      logic [9:0]  n;
      logic [32:0] e;
      logic [31:0] exp_res;
      logic [4:0]  exp_dest;
      instr_valid = vld;
      instr_word  = w;
      tick_en     = tk;
      legal = (w[31:26] == 6'd31) && (w[10:1] == 10'd339) && !w[0];
      n     = {w[15:11], w[20:16]};
      e     = expect_of(n, tb_model);
      if (tk) tb_model = tb_model + 64'd1;
      exp_res  = vld ? (legal ? e[31:0] : 32'd0) : last_result;
      exp_dest = vld ? w[25:21] : last_dest;
      @(posedge clk);
      #1;
      check({tag, " result"}, 64'(result), 64'(exp_res));
      check({tag, " dest"}, 64'(dest_idx), 64'(exp_dest));
      check({tag, " wr_en"}, 64'(wr_en), 64'(vld && legal));
      check({tag, " pc_adv"}, 64'(pc_adv), 64'(vld && legal));
      check({tag, " warn"}, 64'(warn_unmod), 64'(vld && legal && e[32]));
      check({tag, " illegal"}, 64'(illegal), 64'(vld && !legal));
      last_result = exp_res;
      last_dest   = exp_dest;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4242));
      xer_val = 32'h2000_0011; link_val = 32'h8001_2340;
      count_val = 32'h0000_0FED; vsave_val = 32'hFFFF_0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      check("R11 result", 64'(result), 64'd0);
      check("R11 dest", 64'(dest_idx), 64'd0);
      check("R11 strobes", 64'({wr_en, pc_adv, warn_unmod, illegal}), 64'd0);
      @(negedge clk);

      // R1 R2 R4 live registers
      step("R4 xer", 1, mk_word(5'd3, 10'd1), 0);
      step("R4 lr", 1, mk_word(5'd31, 10'd8), 0);
      step("R4 ctr", 1, mk_word(5'd0, 10'd9), 0);
      step("R4 vsave", 1, mk_word(5'd17, 10'd256), 0);
      // R3 raw encoding: field 0x100 selects register 8
      step("R3 raw", 1, 32'h7C00_0000 | (32'd4 << 21) | (32'h100 << 11) | (32'd339 << 1), 0);
      check("R3 lr value", 64'(result), 64'(link_val));
      // R6 version constant
      step("R6 pvr", 1, mk_word(5'd9, 10'd287), 0);
      // R5 time base across the carry
      step("R5 tbl pre", 1, mk_word(5'd1, 10'd268), 1);
      step("R5 tbu pre", 1, mk_word(5'd2, 10'd269), 1);
      for (int i = 0; i < 4; i++) step("R5 tick", 0, 32'd0, 1);
      step("R5 tbu post", 1, mk_word(5'd2, 10'd269), 0);
      step("R5 tbl post", 1, mk_word(5'd1, 10'd268), 0);
      check("R5 carry high", 64'(tb_model[63:32]), 64'd1);
      // R7 stubs
      foreach (stub_list[i]) step("R7 stub", 1, mk_word(5'd6, stub_list[i]), 0);
      // R8 unmodelled
      step("R8 dec22", 1, mk_word(5'd7, 10'd22), 0);
      step("R8 n0", 1, mk_word(5'd7, 10'd0), 0);
      step("R8 n1022", 1, mk_word(5'd7, 10'd1022), 0);
      // R9 illegal forms
      step("R9 rsvd", 1, mk_word(5'd8, 10'd8) | 32'd1, 0);
      step("R9 primary", 1, mk_word(5'd8, 10'd8) ^ 32'h0400_0000, 0);
      step("R9 ext", 1, mk_word(5'd8, 10'd8) ^ 32'h0000_0002, 0);
      // R10 idle holds
      step("R10 load", 1, mk_word(5'd12, 10'd9), 0);
      step("R10 idle", 0, mk_word(5'd20, 10'd1), 0);
      step("R10 idle2", 0, 32'hFFFF_FFFF, 1);

      // Random mix
      for (int k = 0; k < 400; k++) begin
         logic [9:0]  n;
         logic [31:0] w;
         int          sel;
         xer_val = $urandom; link_val = $urandom;
         count_val = $urandom; vsave_val = $urandom;
         sel = int'($urandom % 4);
         n = (sel == 0) ? pick_list[$urandom % 16] : 10'($urandom);
         w = mk_word(5'($urandom), n);
         case (int'($urandom % 8))
            0: w[0] = 1'b1;
            1: w[31:26] = 6'($urandom);
            2: w[10:1] = 10'($urandom);
            default: ;
         endcase
         step("R1 R8 random", ($urandom % 5) != 0, w, ($urandom % 2) == 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   logic [9:0] stub_list [9] = '{10'd18, 10'd19, 10'd272, 10'd273, 10'd274,
                                 10'd275, 10'd1008, 10'd1009, 10'd1023};
   logic [9:0] pick_list [16] = '{10'd1, 10'd8, 10'd9, 10'd256, 10'd268, 10'd269,
                                  10'd287, 10'd18, 10'd19, 10'd272, 10'd275,
                                  10'd1008, 10'd1009, 10'd1023, 10'd22, 10'd288};

endmodule